// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned operands of `OPW` bits each. It uses one adder and spends one clock per multiplier bit. A pulse on `start` while the block is idle loads the multiplicand and the multiplier and clears the accumulator. After that, each cycle looks at the lowest bit of the multiplier register. When that bit is 1, the cycle adds the multiplicand into the accumulator. Either way, the cycle then moves the whole carry:accumulator:multiplier chain one place toward the low end. The carry out of the add becomes the new top bit of the accumulator, and the accumulator's low bit enters the top of the multiplier register. After `OPW` cycles, the double-width product sits in accumulator:multiplier.

`done` is high for exactly one cycle when the product is ready. The product then stays unchanged until the next accepted `start`. A parameter selects the adder: either the synthesis tool's own adder operator or an explicit chain of full adders. Both produce the same results.

Top module: `seq_shift_add_mul`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `done` is 0 and `product` is 0.
- R2: A `start` sampled high while idle loads `op_a` (multiplicand) and `op_b` (multiplier). When `done` next rises, `product` equals op_a*op_b as an unsigned 2*OPW-bit number.
- R3: `done` is high in exactly one cycle: the cycle that follows the OPW-th rising clock edge after the edge that accepted `start`.
- R4: A `start` sampled while a multiplication is running is ignored. The running result and its timing are unchanged.
- R5: While the block is idle and `start` is low, `product` does not change, even when `op_a` and `op_b` change.
- R6: The carry out of every accumulator add is kept. With both operands all ones, the product is (2^OPW-1)^2.
- R7: If either operand is zero, the product is zero.
- R8: A `start` sampled in the same cycle that `done` is high is accepted, and a new multiplication begins at once.
- R9: Both adder variants (ADDER_STYLE 0 = built-in addition, 1 = full-adder chain) give identical `product` and `done` for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiplication; accepted only when idle |
| op_a | input | OPW | Unsigned multiplicand |
| op_b | input | OPW | Unsigned multiplier |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2*OPW | Accumulator:multiplier register pair |

## Verification
The assertions check the following on every cycle: that `done` pulses alone, that it arrives exactly OPW cycles after an accepted start, that the product then matches the operands captured at acceptance, and that the product holds while the block is idle. Some behaviours only the bench's scenarios can show. These are the full operand sweep, including all-ones carries and zero operands, the rejection of a start while busy, a back-to-back start in the `done` cycle, and the agreement of the two adder variants.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } mul_state_e;

   localparam int ADD_BUILTIN = 0;
   localparam int ADD_CHAIN   = 1;
endpackage

// File: rtl/seq_mul_adder.sv
module seq_mul_adder #(
   parameter int W     = 8,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] sum,
   output logic         cout
);
   import seq_mul_pkg::*;

   generate
      if (STYLE == ADD_CHAIN) begin : g_chain
         logic [W:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_fa
            assign sum[i]  = x[i] ^ y[i] ^ cy[i];
            assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
         end
         assign cout = cy[W];
      end else begin : g_builtin
         logic [W:0] wide;
         assign wide = {1'b0, x} + {1'b0, y};
         assign sum  = wide[W-1:0];
         assign cout = wide[W];
      end
   endgenerate
endmodule

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl #(
   parameter int OPW = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic running,
   output logic done
);
   import seq_mul_pkg::*;

   localparam int CNTW = (OPW > 2) ? $clog2(OPW) : 1;
   localparam logic [CNTW-1:0] LAST_LOAD = CNTW'(OPW - 1);

   mul_state_e      state_q;
   logic [CNTW-1:0] left_q;
   logic            done_q;

   assign running = (state_q == ST_RUN);
   assign load    = start && (state_q == ST_IDLE);
   assign step    = running;
   assign done    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            state_q <= ST_RUN;
            left_q  <= LAST_LOAD;
         end else if (running) begin
            if (left_q == '0) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end else begin
               left_q <= left_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/seq_mul_dp.sv
module seq_mul_dp #(
   parameter int OPW         = 8,
   parameter int ADDER_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [OPW-1:0]   mcand,
   input  logic [OPW-1:0]   mplier,
   output logic [2*OPW-1:0] prod
);
   logic [OPW-1:0] m_q;
   logic [OPW-1:0] acc_q;
   logic [OPW-1:0] q_q;
   logic [OPW-1:0] addend;
   logic [OPW-1:0] sum;
   logic           carry;

   assign addend = q_q[0] ? m_q : '0;

   seq_mul_adder #(.W(OPW), .STYLE(ADDER_STYLE)) u_add (
      .x   (acc_q),
      .y   (addend),
      .sum (sum),
      .cout(carry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q   <= '0;
         acc_q <= '0;
         q_q   <= '0;
      end else if (load) begin
         m_q   <= mcand;
         acc_q <= '0;
         q_q   <= mplier;
      end else if (step) begin
         acc_q <= {carry, sum[OPW-1:1]};
         q_q   <= {sum[0], q_q[OPW-1:1]};
      end
   end

   assign prod = {acc_q, q_q};
endmodule

// File: rtl/seq_shift_add_mul.sv
module seq_shift_add_mul #(
   parameter int OPW         = 8,
   parameter int ADDER_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OPW-1:0]   op_a,
   input  logic [OPW-1:0]   op_b,
   output logic             done,
   output logic [2*OPW-1:0] product
);
   generate
      if (OPW < 2) begin : g_bad_width
         $error("seq_shift_add_mul: OPW must be at least 2");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("seq_shift_add_mul: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   logic load_w;
   logic step_w;
   logic run_w;

   seq_mul_ctrl #(.OPW(OPW)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .load   (load_w),
      .step   (step_w),
      .running(run_w),
      .done   (done)
   );

   seq_mul_dp #(.OPW(OPW), .ADDER_STYLE(ADDER_STYLE)) u_dp (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_w),
      .step  (step_w),
      .mcand (op_a),
      .mplier(op_b),
      .prod  (product)
   );
endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
   parameter int OPW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [OPW-1:0]   op_a,
   input logic [OPW-1:0]   op_b,
   input logic             done,
   input logic [2*OPW-1:0] product,
   input logic             run
);
   localparam int CW = $clog2(OPW + 1) + 1;

   logic [2*OPW-1:0] want_q;
   logic [CW-1:0]    cyc_q;
   logic             pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         want_q <= '0;
         cyc_q  <= '0;
         pend_q <= 1'b0;
      end else if (start && !run) begin
         want_q <= {{OPW{1'b0}}, op_a} * {{OPW{1'b0}}, op_b};
         cyc_q  <= '0;
         pend_q <= 1'b1;
      end else if (done) begin
         pend_q <= 1'b0;
      end else if (pend_q) begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pend_q && cyc_q == CW'(OPW)));

   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_product_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (product == want_q));

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> $stable(product));

   assert_done_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !run);
endmodule

bind seq_shift_add_mul seq_mul_chk #(.OPW(OPW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .op_a   (op_a),
   .op_b   (op_b),
   .done   (done),
   .product(product),
   .run    (run_w)
);

// File: tb/seq_shift_add_mul_bench.sv
module seq_shift_add_mul_bench;
   localparam int W  = 4;
   localparam int PW = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  a = '0;
   logic [W-1:0]  b = '0;
   logic          done0, done1;
   logic [PW-1:0] prod0, prod1;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   seq_shift_add_mul #(.OPW(W), .ADDER_STYLE(0)) u_seq_shift_add_mul (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(a), .op_b(b),
      .done(done0), .product(prod0)
   );

   seq_shift_add_mul #(.OPW(W), .ADDER_STYLE(1)) u_seq_shift_add_mul_chain (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(a), .op_b(b),
      .done(done1), .product(prod1)
   );

   task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Launch at a negedge; returns at the negedge that follows the done edge.
   task automatic launch_and_finish(input logic [W-1:0] x, input logic [W-1:0] y,
                                    input string req, input bit disturb);
      logic [PW-1:0] exp;
      exp = PW'(x) * PW'(y);
      a = x; b = y; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 1; i <= W; i++) begin
         if (disturb && i == 2) begin
            a = ~x; b = ~y; start = 1'b1;   // R4: ignored while busy
         end
         @(negedge clk);
         start = 1'b0;
         if (i < W) check("R3 done early", PW'(done0), '0);
      end
      check("R3 done at OPW", PW'(done0), 1);
      check(req, prod0, exp);
      check("R9 chain product", prod1, prod0);
      check("R9 chain done", PW'(done1), PW'(done0));
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [PW-1:0] held;
      repeat (3) @(negedge clk);
      check("R1 done in reset", PW'(done0), '0);
      check("R1 product in reset", prod0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done after reset", PW'(done0), '0);
      check("R1 product after reset", prod0, '0);

      // R2, R6, R7: exhaustive sweep
      for (int x = 0; x < (1 << W); x++) begin
         for (int y = 0; y < (1 << W); y++) begin
            string tag;
            if (x == 0 || y == 0) tag = "R7 zero operand";
            else if (x == (1 << W) - 1 && y == (1 << W) - 1) tag = "R6 all ones carry";
            else tag = "R2 product";
            launch_and_finish(W'(x), W'(y), tag, 1'b0);
            @(negedge clk);
            check("R3 single pulse", PW'(done0), '0);
         end
      end

      // R4: start while busy
      launch_and_finish(4'd13, 4'd11, "R4 busy start ignored", 1'b1);
      @(negedge clk);
      check("R3 pulse after busy start", PW'(done0), '0);
      check("R4 result kept", prod0, 8'd143);

      // R5: hold while idle with changing operands
      held = prod0;
      for (int k = 0; k < 6; k++) begin
         a = W'(k * 3); b = W'(k + 5);
         @(negedge clk);
         check("R5 product held", prod0, held);
         check("R5 no done", PW'(done0), '0);
      end

      // R8: back-to-back start in done cycle
      launch_and_finish(4'd9, 4'd7, "R2 first of pair", 1'b0);
      launch_and_finish(4'd15, 4'd14, "R8 back-to-back", 1'b0);
      @(negedge clk);
      check("R8 pulse ends", PW'(done0), '0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule